// File: doc/BRIEF.md
# Register-Bank Target on a Two-Wire Serial Bus

This block is a target device on an I2C bus that gives a bus controller access to a bank of eight byte-wide registers. The controller writes a register by sending the target address, a register index and one or more data bytes. It reads in the combined format: a write phase sets the register index, a repeated START follows, and the address is then sent again with the read bit set. The target returns the indexed register and keeps returning the following registers for as long as the controller acknowledges.

The bus pins are a sampled clock input, a sampled data input and one open-drain enable. When the enable is high, the data line is pulled low. Both bus inputs pass through synchronizers clocked by the system clock, which must run at least eight times faster than the bus clock. A synchronous reset stands in for power-on reset. While it is held, the target takes no part in bus traffic. The register contents are visible in parallel on a flat output vector. The last register is a read-only status byte that is fed from an input port.

The block carries no streaming payload, so it has no valid/ready handshake. The only back-pressure is the acknowledge bit on the bus.

Top module: `i2c_regbank_target`

## Requirements
- R1: The target answers to the 7-bit address 0x44. This address occupies bits 7..1 of the first byte after START, and bit 0 is the direction bit (0 = write, 1 = read). On a match the target pulls SDA low during the 9th clock. On any other address it never drives SDA until the next START or STOP.
- R2: In a write (START, address with bit 0 = 0, index byte, data byte, STOP) the target acknowledges all three bytes, and the data byte lands in the indexed register.
- R3: In a read, the index byte is followed by a repeated START and the address with bit 0 = 1. The target acknowledges, then shifts out the indexed register MSB first, one bit per SCL clock.
- R4: After each read byte, a controller ACK (SDA low on the 9th clock) makes the target send the next register. A NACK makes the target release SDA and stay silent until STOP or START.
- R5: The register index is bits 2..0 of the index byte. It advances by one after every data byte read or written, and wraps from 7 to 0.
- R6: Register 7 reads back the `status_i` input. A write to it is acknowledged but changes no register.
- R7: While `rst` is high, SDA is released and no byte is acknowledged. After reset every writable register reads 0.
- R8: A START or STOP that arrives partway through a byte abandons that byte without writing it. After a START the target expects an address byte.
- R9: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous reset, active high (power-on reset) |
| scl_i | input | 1 | Bus clock as seen at the pin |
| sda_i | input | 1 | Bus data as seen at the pin |
| sda_oe | output | 1 | High pulls the SDA line low (open drain) |
| status_i | input | 8 | Value returned by read-only register 7 |
| regs_o | output | 64 | All registers, register k in bits 8k+7..8k |

## Verification
On every cycle, the assertions check that:
- the SDA drive is released during reset, after a controller NACK and after an address mismatch;
- the SDA drive rises only while SCL is low;
- a write to the status register leaves every other register unchanged.

The bench scenarios cover the behaviours that depend on the whole bus sequence:
- all 128 addresses are swept against the single one that matches;
- every register is written and then read back;
- a burst read wraps past the status register;
- index bits above bit 2 are ignored;
- a mid-byte STOP or START discards the partial byte.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK_W,
    S_AACK_R,
    S_REG,
    S_RACK,
    S_WDAT,
    S_DACK,
    S_TX,
    S_MACK,
    S_IGN
  } st_t;
endpackage

// File: rtl/i2ct_busfront.sv
module i2ct_busfront #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_h,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_h     = scl_q[STAGES-1];
  assign sda_h     = sda_q[STAGES-1];
  assign scl_rise  = scl_h & ~scl_p;
  assign scl_fall  = ~scl_h & scl_p;
  assign start_det = scl_h & scl_p & sda_p & ~sda_h;
  assign stop_det  = scl_h & scl_p & ~sda_p & sda_h;
endmodule

// File: rtl/i2ct_regfile.sv
module i2ct_regfile #(
  parameter int NREG   = 8,
  parameter int RO_IDX = 7,
  localparam int PW    = $clog2(NREG),
  localparam int BW    = i2ct_pkg::BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PW-1:0]    widx,
  input  logic [BW-1:0]    wdata,
  input  logic [PW-1:0]    ridx,
  output logic [BW-1:0]    rdata,
  input  logic [BW-1:0]    status_i,
  output logic [NREG*BW-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == RO_IDX) begin : g_ro
      assign regs_o[g*BW +: BW] = status_i;
    end else begin : g_rw
      logic [BW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (we && widx == PW'(g)) q <= wdata;
      end
      assign regs_o[g*BW +: BW] = q;
    end
  end

  assign rdata = regs_o[ridx*BW +: BW];
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h44,
  parameter int NREG   = 8,
  parameter int RO_IDX = 7,
  parameter int SYNC   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [BYTE_W-1:0]     status_i,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  localparam int PW = $clog2(NREG);
  localparam int CW = $clog2(BYTE_W + 1);

  st_t               state;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic [PW-1:0]     ptr;
  logic              mack;
  logic              sda_h, scl_rise, scl_fall, start_det, stop_det;
  logic              byte_done, rf_we, load_rd;
  logic [BYTE_W-1:0] rdata;

  i2ct_busfront #(.STAGES(SYNC)) u_front (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_h(sda_h),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NREG - 1)) ? '0 : p + 1'b1;
  endfunction

  assign byte_done = scl_fall && (cnt == CW'(BYTE_W));
  assign rf_we     = !start_det && !stop_det && state == S_WDAT && byte_done;
  assign load_rd   = !start_det && !stop_det && scl_fall &&
                     (state == S_AACK_R || (state == S_MACK && mack));

  i2ct_regfile #(.NREG(NREG), .RO_IDX(RO_IDX)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .widx(ptr), .wdata(sh),
    .ridx(ptr), .rdata(rdata), .status_i(status_i), .regs_o(regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (load_rd) begin
      sh     <= rdata;
      sda_oe <= ~rdata[BYTE_W-1];
      ptr    <= nxt(ptr);
      cnt    <= '0;
      state  <= S_TX;
    end else begin
      case (state)
        S_ADDR, S_REG, S_WDAT: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_h};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            if (state == S_ADDR) begin
              if (sh[7:1] == TGT_ADDR) begin
                sda_oe <= 1'b1;
                state  <= sh[0] ? S_AACK_R : S_AACK_W;
              end else begin
                state <= S_IGN;
              end
            end else if (state == S_REG) begin
              ptr    <= sh[PW-1:0];
              sda_oe <= 1'b1;
              state  <= S_RACK;
            end else begin
              ptr    <= nxt(ptr);
              sda_oe <= 1'b1;
              state  <= S_DACK;
            end
          end
        end
        S_AACK_W, S_RACK, S_DACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= (state == S_AACK_W) ? S_REG : S_WDAT;
          end
        end
        S_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            sda_oe <= 1'b0;
            state  <= S_MACK;
          end else if (scl_fall) begin
            sda_oe <= ~sh[BYTE_W-2];
            sh     <= {sh[BYTE_W-2:0], 1'b0};
          end
        end
        S_MACK: begin
          if (scl_rise) mack <= ~sda_h;
          else if (scl_fall) state <= S_IGN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
  import i2ct_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int RO_IDX = 7,
  localparam int PW    = $clog2(NREG),
  localparam int VW    = NREG * BYTE_W
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input st_t           st,
  input logic          wr_en,
  input logic [PW-1:0] wr_idx,
  input logic [VW-1:0] regs_o
);
  localparam logic [VW-1:0] RO_MASK = {{(VW-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} << (RO_IDX * BYTE_W);

  assert_ign_silent_R1: assert property (@(posedge clk) disable iff (rst)
    st == S_IGN |-> !sda_oe);

  assert_nack_release_R4: assert property (@(posedge clk) disable iff (rst)
    st == S_MACK |-> !sda_oe);

  assert_ro_no_effect_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == PW'(RO_IDX)) |=> ((regs_o & ~RO_MASK) == ($past(regs_o) & ~RO_MASK)));

  assert_rst_quiet_R7: assert property (@(posedge clk)
    rst |=> !sda_oe);

  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind i2c_regbank_target i2ct_checker #(.NREG(NREG), .RO_IDX(RO_IDX)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .st(state),
  .wr_en(rf_we), .wr_idx(ptr), .regs_o(regs_o)
);

// File: tb/sim_i2c_regbank_target.sv
`timescale 1ns/1ps
module sim_i2c_regbank_target;
  localparam int Q = 8;
  localparam logic [6:0] TA = 7'h44;
  localparam logic [7:0] STAT = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [63:0] regs_o;
  logic [7:0] expv [8];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  i2c_regbank_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .status_i(STAT), .regs_o(regs_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic b_start();
    m_low = 1'b0; cyc(Q); scl = 1'b1; cyc(Q); m_low = 1'b1; cyc(Q); scl = 1'b0; cyc(2);
  endtask

  task automatic b_stop();
    m_low = 1'b1; cyc(Q); scl = 1'b1; cyc(Q); m_low = 1'b0; cyc(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; cyc(Q); scl = 1'b1; cyc(Q); scl = 1'b0; cyc(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_low = 1'b0; cyc(Q); scl = 1'b1; cyc(Q/2);
    ack = ~sda_line;
    cyc(Q/2); scl = 1'b0; cyc(2);
  endtask

  task automatic recv_byte(input bit more, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      cyc(Q); scl = 1'b1; cyc(Q/2); b[i] = sda_line; cyc(Q/2); scl = 1'b0; cyc(2);
    end
    m_low = more; cyc(Q); scl = 1'b1; cyc(Q); scl = 1'b0; cyc(2); m_low = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] ra, input logic [7:0] d, input string tag);
    bit a0, a1, a2;
    b_start();
    send_byte({TA, 1'b0}, a0);
    send_byte(ra, a1);
    send_byte(d, a2);
    b_stop();
    chk(a0 && a1 && a2, tag, {a0, a1, a2}, 3'b111);
    if (ra[2:0] != 3'd7) expv[ra[2:0]] = d;
  endtask

  task automatic rd_burst(input logic [7:0] ra, input int n, input string tag);
    bit a0, a1, a2;
    logic [7:0] b;
    int idx;
    b_start();
    send_byte({TA, 1'b0}, a0);
    send_byte(ra, a1);
    b_start();
    send_byte({TA, 1'b1}, a2);
    chk(a0 && a1 && a2, tag, {a0, a1, a2}, 3'b111);
    for (int k = 0; k < n; k++) begin
      idx = (ra[2:0] + k) % 8;
      recv_byte(k < n - 1, b);
      chk(b == expv[idx], tag, b, expv[idx]);
    end
    cyc(Q);
    chk(sda_oe == 1'b0, "R4 released after NACK", sda_oe, 0);
    b_stop();
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < 8; i++)
      chk(regs_o[i*8 +: 8] == expv[i], tag, regs_o[i*8 +: 8], expv[i]);
  endtask

  initial begin
    bit a0, a1, a2;
    for (int i = 0; i < 7; i++) expv[i] = 8'h00;
    expv[7] = STAT;
    cyc(4);
    // R7: traffic during reset is refused
    b_start();
    send_byte({TA, 1'b0}, a0);
    send_byte(8'h01, a1);
    send_byte(8'hFF, a2);
    b_stop();
    chk({a0, a1, a2} == 3'b000, "R7 no ack in reset", {a0, a1, a2}, 0);
    chk(sda_oe == 1'b0, "R7 sda released", sda_oe, 0);
    rst = 1'b0;
    cyc(4);
    chk_regs("R7 defaults");

    // R2: write each register, R6: status register write ignored
    for (int i = 0; i < 8; i++) wr_reg(8'(i), 8'(i * 37 + 5), "R2 write ack");
    chk_regs("R2/R6 contents");
    // R3: single reads of every register
    for (int i = 0; i < 8; i++) rd_burst(8'(i), 1, "R3 single read");
    // R4/R5: burst from 5 wraps through status register
    rd_burst(8'h05, 6, "R4 R5 burst wrap");
    // R5: upper index bits ignored
    wr_reg(8'h0B, 8'hC3, "R5 index low bits");
    chk(regs_o[3*8 +: 8] == 8'hC3, "R5 index low bits", regs_o[3*8 +: 8], 8'hC3);
    rd_burst(8'h13, 1, "R5 index low bits read");
    // R5/R6: write burst starting at status register wraps to 0
    b_start();
    send_byte({TA, 1'b0}, a0);
    send_byte(8'h07, a1);
    send_byte(8'h11, a2);
    chk(a2, "R6 ro write acked", a2, 1);
    send_byte(8'h22, a2);
    b_stop();
    expv[0] = 8'h22;
    chk_regs("R5 R6 write wrap");

    // R1: exhaustive address sweep
    for (int a = 0; a < 128; a++) begin
      b_start();
      send_byte({7'(a), 1'b0}, a0);
      chk(a0 == (7'(a) == TA), "R1 address match", a0, 7'(a) == TA);
      if (7'(a) != TA) begin
        send_byte(8'h02, a1);
        chk(a1 == 1'b0, "R1 ignore after mismatch", a1, 0);
        send_byte(8'h77, a1);
      end
      b_stop();
    end
    chk_regs("R1 no write on mismatch");

    // R8: STOP in the middle of a data byte
    b_start();
    send_byte({TA, 1'b0}, a0);
    send_byte(8'h02, a1);
    send_bits(8'hA0, 4);
    b_stop();
    chk_regs("R8 stop abort");
    // R8: START in the middle of the index byte
    b_start();
    send_byte({TA, 1'b0}, a0);
    send_bits(8'h60, 3);
    b_start();
    send_byte({TA, 1'b0}, a0);
    send_byte(8'h01, a1);
    send_byte(8'h5A, a2);
    b_stop();
    chk(a0 && a1 && a2, "R8 start abort acks", {a0, a1, a2}, 3'b111);
    expv[1] = 8'h5A;
    chk_regs("R8 start abort");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule